// File: doc/BRIEF.md
# Configurable CRC Accelerator

This block is a register-mapped CRC engine that sits on a simple 32-bit processor register port. Software picks a mode through the control register, writes the seed it wants, starts a new calculation by writing the initialise bit, and then writes message data to the data register. Each data write can be a byte, a half-word or a full word placed in any lane; the engine folds every enabled byte into the running checksum in the same clock cycle, so the result register is up to date on the next cycle.

Two generators are available: a 16-bit one (polynomial 0x1021) and a 32-bit one (polynomial 0x04C11DB7). The order in which the bytes of a word enter the engine and the bit order inside each byte can both be chosen. The bit order, byte order and final inversion of the readout can also be chosen, and none of these change the internal state. In the 16-bit mode the result moves between the low and high half of the result word, depending on whether the input and output byte orders agree. Feeding a message followed by its own 16-bit checksum, high byte first, leaves zero, so the same engine can check received data.

Register word index (`bus_word_addr`): 0 = control, 1 = seed, 2 = data input, 3 = result. Control bits: 0 = initialise (action only), 1 = 32-bit mode, 2 = input little-endian, 3 = input LSB-first, 4 = output little-endian, 5 = output LSB-first, 6 = final inversion.

Top module: `crc_engine`

## Requirements
- R1: After reset the control register reads 0x00000000, the seed register reads 0xFFFFFFFF and the result register reads 0x0000FFFF (16-bit mode, all options clear).
- R2: A control write with byte lane 0 enabled stores bits 6:1. When bit 0 is also 1, the state is loaded from the seed (the low 16 bits only in 16-bit mode, using the mode just written). Bit 0 always reads back as 0, as do bits 31:7.
- R3: In 16-bit mode with all options clear and seed 0xFFFF, the single bytes 0x31 to 0x39 give a result of 0x000029B1.
- R4: Appending the bytes 0x29 then 0xB1 to that message gives a result of 0x00000000.
- R5: Every byte lane enabled in a data write is folded in during that cycle. When input little-endian (bit 2) is 0, lane 3 (bits 31:24) goes first and lane 0 goes last. When bit 2 is 1, lane 0 goes first. Disabled lanes are skipped.
- R6: When input LSB-first (bit 3) is set, each byte is bit-reversed before it enters the generator. With bits 3 and 5 set and seed 0xFFFF, the digits give 0x00006F91.
- R7: In 32-bit mode (bit 1) the generator is 0x04C11DB7 and the result fills all 32 bits. With seed 0xFFFFFFFF the digits give 0x0376E6E7. With bits 1, 3, 5 and 6 set they give 0xCBF43926.
- R8: Final inversion (bit 6) inverts the readout across the active width. Output LSB-first (bit 5) bit-reverses the readout across the active width. Changing either bit without initialising leaves the state untouched.
- R9: Output little-endian (bit 4) reverses the byte order of the active-width result. In 16-bit mode the result is in bits 15:0 when bits 2 and 4 are equal and in bits 31:16 when they differ, and the other half reads zero.
- R10: A seed write updates only the enabled bytes of the seed and leaves the state unchanged until the next initialise.
- R11: A data write with no byte enabled, a write to the result register, and a control write with lane 0 disabled all leave the state and control unchanged. The data register reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_word_addr | input | 2 | Register word index |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, combinational |

## Verification
The assertions check several properties on every cycle: an initialise loads the seed at the selected width, seed writes and idle or empty writes leave the state unchanged, the control readout keeps its action bit and unused bits at zero, the data register reads zero, and the 16-bit result sits in the half picked by the two byte-order bits. The checksum values themselves, the order in which lanes are consumed, bit reversal on input and output, and the self-check to zero can only be shown by the bench. Its behavioural model, which processes the bytes one bit at a time from a queue, is compared with the read port on every cycle, and the bench also checks known checksum values for the standard variants.

// File: rtl/crc_pkg.sv
package crc_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned LANES  = DATA_W / 8;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_SEED   = 2'd1,
    SEL_DATA   = 2'd2,
    SEL_RESULT = 2'd3
  } reg_sel_e;

  // Packed so that the struct lines up with control bits 6:1.
  typedef struct packed {
    logic fxor;     // bit 6
    logic out_lsb;  // bit 5
    logic out_le;   // bit 4
    logic in_lsb;   // bit 3
    logic in_le;    // bit 2
    logic wide;     // bit 1
  } crc_mode_t;

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  function automatic logic [15:0] rev16(input logic [15:0] v);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = v[15-i];
    return r;
  endfunction

  function automatic logic [31:0] rev32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

endpackage

// File: rtl/crc_rst_sync.sv
module crc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) chain_q <= '0;
    else              chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/crc_lane_order.sv
// Reorders the write lanes into processing order (slot 0 is consumed first).
module crc_lane_order #(
  parameter int unsigned LANES = 4
) (
  input  logic [LANES*8-1:0] data,
  input  logic [LANES-1:0]   be,
  input  logic               little,
  output logic [LANES*8-1:0] ord_data,
  output logic [LANES-1:0]   ord_vld
);

  for (genvar k = 0; k < LANES; k++) begin : g_slot
    localparam int unsigned HI = LANES - 1 - k;
    assign ord_data[k*8 +: 8] = little ? data[k*8 +: 8] : data[HI*8 +: 8];
    assign ord_vld[k]         = little ? be[k]          : be[HI];
  end

endmodule

// File: rtl/crc_byte_step.sv
// Folds one byte into a W-bit MSB-first CRC state; passes through when idle.
module crc_byte_step
  import crc_pkg::*;
#(
  parameter int unsigned     W    = 16,
  parameter logic [W-1:0]    POLY = '1
) (
  input  logic         en,
  input  logic         in_lsb,
  input  logic [7:0]   din,
  input  logic [W-1:0] crc_in,
  output logic [W-1:0] crc_out
);

  logic [7:0]   byte_v;
  logic [W-1:0] acc;

  always_comb begin
    byte_v = in_lsb ? rev8(din) : din;
    acc    = crc_in ^ {byte_v, {(W-8){1'b0}}};
    for (int i = 0; i < 8; i++) begin
      acc = acc[W-1] ? ((acc << 1) ^ POLY) : (acc << 1);
    end
    crc_out = en ? acc : crc_in;
  end

endmodule

// File: rtl/crc_result_fmt.sv
// Builds the result-register word from the state and the output options.
module crc_result_fmt
  import crc_pkg::*;
(
  input  logic [31:0] state,
  input  crc_mode_t   mode,
  output logic [31:0] word
);

  logic [31:0] v32;
  logic [15:0] v16;

  always_comb begin
    v32 = mode.fxor ? ~state : state;
    if (mode.out_lsb) v32 = rev32(v32);
    if (mode.out_le)  v32 = {v32[7:0], v32[15:8], v32[23:16], v32[31:24]};

    v16 = mode.fxor ? ~state[15:0] : state[15:0];
    if (mode.out_lsb) v16 = rev16(v16);
    if (mode.out_le)  v16 = {v16[7:0], v16[15:8]};

    if (mode.wide)                     word = v32;
    else if (mode.out_le != mode.in_le) word = {v16, 16'h0000};
    else                               word = {16'h0000, v16};
  end

endmodule

// File: rtl/crc_engine.sv
module crc_engine
  import crc_pkg::*;
#(
  parameter logic [15:0] CRC16_POLY  = 16'h1021,
  parameter logic [31:0] CRC32_POLY  = 32'h04C1_1DB7,
  parameter logic [31:0] SEED_RST    = 32'hFFFF_FFFF,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [1:0]        bus_word_addr,
  input  logic [LANES-1:0]  bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);

  logic rst_n_s;

  crc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n_async(rst_n),
    .rst_n_sync (rst_n_s)
  );

  reg_sel_e    sel;
  crc_mode_t   mode_q, mode_d;
  logic [31:0] seed_q, seed_d;
  logic [31:0] state_q, state_d;
  logic        mode_en, seed_en, state_en;
  logic [31:0] res_word;

  assign sel = reg_sel_e'(bus_word_addr);

  // ---------------- byte ordering ----------------
  logic [DATA_W-1:0] ord_data;
  logic [LANES-1:0]  ord_vld;

  crc_lane_order #(.LANES(LANES)) u_order (
    .data    (bus_wdata),
    .be      (bus_be),
    .little  (mode_q.in_le),
    .ord_data(ord_data),
    .ord_vld (ord_vld)
  );

  // ---------------- per-width byte chains ----------------
  logic [LANES:0][15:0] c16;
  logic [LANES:0][31:0] c32;

  assign c16[0] = state_q[15:0];
  assign c32[0] = state_q;

  for (genvar k = 0; k < LANES; k++) begin : g_step
    crc_byte_step #(.W(16), .POLY(CRC16_POLY)) u_s16 (
      .en     (ord_vld[k]),
      .in_lsb (mode_q.in_lsb),
      .din    (ord_data[k*8 +: 8]),
      .crc_in (c16[k]),
      .crc_out(c16[k+1])
    );
    crc_byte_step #(.W(32), .POLY(CRC32_POLY)) u_s32 (
      .en     (ord_vld[k]),
      .in_lsb (mode_q.in_lsb),
      .din    (ord_data[k*8 +: 8]),
      .crc_in (c32[k]),
      .crc_out(c32[k+1])
    );
  end

  // ---------------- next state ----------------
  always_comb begin
    mode_d   = mode_q;
    seed_d   = seed_q;
    state_d  = state_q;
    mode_en  = 1'b0;
    seed_en  = 1'b0;
    state_en = 1'b0;

    if (bus_we && sel == SEL_CTRL && bus_be[0]) begin
      mode_en = 1'b1;
      mode_d  = crc_mode_t'(bus_wdata[6:1]);
      if (bus_wdata[0]) begin
        state_en = 1'b1;
        state_d  = mode_d.wide ? seed_q : {16'h0000, seed_q[15:0]};
      end
    end

    if (bus_we && sel == SEL_SEED && (|bus_be)) begin
      seed_en = 1'b1;
      for (int k = 0; k < LANES; k++) begin
        if (bus_be[k]) seed_d[k*8 +: 8] = bus_wdata[k*8 +: 8];
      end
    end

    if (bus_we && sel == SEL_DATA && (|bus_be)) begin
      state_en = 1'b1;
      state_d  = mode_q.wide ? c32[LANES] : {16'h0000, c16[LANES]};
    end
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      mode_q  <= '0;
      seed_q  <= SEED_RST;
      state_q <= SEED_RST;
    end else begin
      if (mode_en)  mode_q  <= mode_d;
      if (seed_en)  seed_q  <= seed_d;
      if (state_en) state_q <= state_d;
    end
  end

  // ---------------- readout ----------------
  crc_result_fmt u_fmt (
    .state(state_q),
    .mode (mode_q),
    .word (res_word)
  );

  always_comb begin
    unique case (sel)
      SEL_CTRL:   bus_rdata = {25'd0, mode_q, 1'b0};
      SEL_SEED:   bus_rdata = seed_q;
      SEL_DATA:   bus_rdata = '0;
      SEL_RESULT: bus_rdata = res_word;
      default:    bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/crc_engine_chk.sv
module crc_engine_chk (
  input logic        clk,
  input logic        rst_n_s,
  input logic        bus_we,
  input logic [1:0]  bus_word_addr,
  input logic [3:0]  bus_be,
  input logic [1:0]  ctrl_wbits,
  input logic [31:0] bus_rdata,
  input logic [31:0] seed_q,
  input logic [31:0] state_q,
  input logic        mode_wide,
  input logic        mode_in_le,
  input logic        mode_out_le
);

  logic init_wr;
  assign init_wr = bus_we && bus_word_addr == 2'd0 && bus_be[0] && ctrl_wbits[0];

  p_init_load_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    init_wr |=> state_q == ($past(ctrl_wbits[1]) ? $past(seed_q)
                                                 : {16'h0000, $past(seed_q[15:0])}));

  p_ctrl_read_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    bus_word_addr == 2'd0 |-> (bus_rdata[0] == 1'b0 && bus_rdata[31:7] == 25'd0));

  p_seed_hold_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_we && bus_word_addr == 2'd1) |=> $stable(state_q));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!bus_we || bus_be == 4'd0 || bus_word_addr == 2'd3) |=> $stable(state_q));

  p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_we && bus_word_addr == 2'd0 && !(bus_be[0] && ctrl_wbits[0])) |=> $stable(state_q));

  p_data_read_r11: assert property (@(posedge clk) disable iff (!rst_n_s)
    bus_word_addr == 2'd2 |-> bus_rdata == 32'd0);

  p_lane_low_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_word_addr == 2'd3 && !mode_wide && mode_in_le == mode_out_le) |-> bus_rdata[31:16] == 16'd0);

  p_lane_high_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_word_addr == 2'd3 && !mode_wide && mode_in_le != mode_out_le) |-> bus_rdata[15:0] == 16'd0);

endmodule

bind crc_engine crc_engine_chk u_chk (
  .clk          (clk),
  .rst_n_s      (rst_n_s),
  .bus_we       (bus_we),
  .bus_word_addr(bus_word_addr),
  .bus_be       (bus_be),
  .ctrl_wbits   (bus_wdata[1:0]),
  .bus_rdata    (bus_rdata),
  .seed_q       (seed_q),
  .state_q      (state_q),
  .mode_wide    (mode_q.wide),
  .mode_in_le   (mode_q.in_le),
  .mode_out_le  (mode_q.out_le)
);

// File: tb/crc_engine_test.sv
module crc_engine_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_word_addr = 2'd0;
  logic [3:0]  bus_be = 4'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;

  always #5 clk = ~clk;

  crc_engine uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_we       (bus_we),
    .bus_word_addr(bus_word_addr),
    .bus_be       (bus_be),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata)
  );

  int n_chk  = 0;
  int n_fail = 0;

  // ---------------- behavioural reference ----------------
  logic [6:0]  m_ctrl;   // bits 6:1 used
  logic [31:0] m_seed;
  logic [31:0] m_state;

  function automatic void m_fold(input logic [7:0] b);
    logic [7:0] x;
    logic       fb;
    x = b;
    if (m_ctrl[3]) for (int i = 0; i < 8; i++) x[i] = b[7-i];
    for (int i = 7; i >= 0; i--) begin
      if (m_ctrl[1]) begin
        fb      = x[i] ^ m_state[31];
        m_state = {m_state[30:0], 1'b0};
        if (fb) m_state = m_state ^ 32'h04C11DB7;
      end else begin
        fb      = x[i] ^ m_state[15];
        m_state = {16'h0000, m_state[14:0], 1'b0};
        if (fb) m_state = m_state ^ 32'h00001021;
      end
    end
  endfunction

  function automatic void m_write(input logic [1:0] a, input logic [3:0] be, input logic [31:0] d);
    logic [7:0] q[$];
    case (a)
      2'd0: if (be[0]) begin
        m_ctrl[6:1] = d[6:1];
        if (d[0]) m_state = m_ctrl[1] ? m_seed : (m_seed & 32'h0000FFFF);
      end
      2'd1: for (int k = 0; k < 4; k++) if (be[k]) m_seed[k*8 +: 8] = d[k*8 +: 8];
      2'd2: begin
        if (m_ctrl[2]) begin
          for (int k = 0; k < 4; k++) if (be[k]) q.push_back(d[k*8 +: 8]);
        end else begin
          for (int k = 3; k >= 0; k--) if (be[k]) q.push_back(d[k*8 +: 8]);
        end
        foreach (q[i]) m_fold(q[i]);
      end
      default: ;
    endcase
  endfunction

  function automatic logic [31:0] m_read(input logic [1:0] a);
    int          w;
    logic [31:0] v, r, mask;
    case (a)
      2'd0: return {25'd0, m_ctrl[6:1], 1'b0};
      2'd1: return m_seed;
      2'd2: return 32'd0;
      default: begin
        w    = m_ctrl[1] ? 32 : 16;
        mask = m_ctrl[1] ? 32'hFFFFFFFF : 32'h0000FFFF;
        v    = m_state & mask;
        if (m_ctrl[6]) v = v ^ mask;
        if (m_ctrl[5]) begin
          r = 0;
          for (int i = 0; i < w; i++) r[w-1-i] = v[i];
          v = r;
        end
        if (m_ctrl[4]) begin
          r = 0;
          for (int i = 0; i < w/8; i++) r[(w/8-1-i)*8 +: 8] = v[i*8 +: 8];
          v = r;
        end
        if (w == 16 && m_ctrl[2] != m_ctrl[4]) v = v << 16;
        return v;
      end
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl  = 7'd0;
      m_seed  = 32'hFFFFFFFF;
      m_state = 32'hFFFFFFFF;
    end else if (bus_we) begin
      m_write(bus_word_addr, bus_be, bus_wdata);
    end
  end

  // Compared on every clock, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      n_chk++;
      if (bus_rdata !== m_read(bus_word_addr)) begin
        n_fail++;
        $display("FAIL R5 per-cycle model, reg %0d: actual %h expected %h",
                 bus_word_addr, bus_rdata, m_read(bus_word_addr));
      end
    end
  end

  // ---------------- driver tasks ----------------
  task automatic wr(input logic [1:0] a, input logic [3:0] be, input logic [31:0] d);
    bus_we = 1'b1; bus_word_addr = a; bus_be = be; bus_wdata = d;
    @(posedge clk); #2;
    bus_we = 1'b0; bus_be = 4'd0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string tag);
    bus_we = 1'b0; bus_word_addr = a;
    @(negedge clk);
    n_chk++;
    if (bus_rdata !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, bus_rdata, exp);
    end
    @(posedge clk); #2;
  endtask

  task automatic digits();
    for (int i = 0; i < 9; i++) wr(2'd2, 4'b0001, 32'h31 + i);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    rd_chk(2'd0, 32'h00000000, "R1 control after reset");
    rd_chk(2'd1, 32'hFFFFFFFF, "R1 seed after reset");
    rd_chk(2'd3, 32'h0000FFFF, "R1 result after reset");
    rd_chk(2'd2, 32'h00000000, "R11 data register reads zero");

    // R3 / R2 / R4
    wr(2'd0, 4'b0001, 32'h01);
    rd_chk(2'd0, 32'h00000000, "R2 init bit reads zero");
    rd_chk(2'd3, 32'h0000FFFF, "R2 state loaded from seed");
    digits();
    rd_chk(2'd3, 32'h000029B1, "R3 16-bit checksum of digits");
    wr(2'd2, 4'b0001, 32'h29);
    wr(2'd2, 4'b0001, 32'hB1);
    rd_chk(2'd3, 32'h00000000, "R4 appended checksum gives zero");

    // R5 word and half-word writes, big-endian order
    wr(2'd0, 4'b0001, 32'h01);
    wr(2'd2, 4'b1111, 32'h31323334);
    wr(2'd2, 4'b1111, 32'h35363738);
    wr(2'd2, 4'b1000, 32'h39000000);
    rd_chk(2'd3, 32'h000029B1, "R5 word writes lane 3 first");
    wr(2'd0, 4'b0001, 32'h01);
    wr(2'd2, 4'b1100, 32'h31320000);
    wr(2'd2, 4'b0011, 32'h00003334);
    wr(2'd2, 4'b1100, 32'h35360000);
    wr(2'd2, 4'b0011, 32'h00003738);
    wr(2'd2, 4'b0010, 32'h00003900);
    rd_chk(2'd3, 32'h000029B1, "R5 half-word writes in any lane");

    // R5 / R9 little-endian input and output lanes
    wr(2'd0, 4'b0001, 32'h05);
    wr(2'd2, 4'b1111, 32'h34333231);
    wr(2'd2, 4'b1111, 32'h38373635);
    wr(2'd2, 4'b0100, 32'h00390000);
    rd_chk(2'd3, 32'h29B10000, "R9 orders differ, upper half");
    wr(2'd0, 4'b0001, 32'h14);
    rd_chk(2'd3, 32'h0000B129, "R9 both little, swapped low half");
    wr(2'd0, 4'b0001, 32'h10);
    rd_chk(2'd3, 32'hB1290000, "R9 output little only, upper half");

    // R8 output options leave the state alone
    wr(2'd0, 4'b0001, 32'h01);
    digits();
    wr(2'd0, 4'b0001, 32'h40);
    rd_chk(2'd3, 32'h0000D64E, "R8 final inversion");
    wr(2'd0, 4'b0001, 32'h00);
    rd_chk(2'd3, 32'h000029B1, "R8 state unchanged by option change");
    wr(2'd0, 4'b0001, 32'h20);
    rd_chk(2'd3, 32'h00008D94, "R8 output bit reversal");

    // R6 input bit reversal
    wr(2'd0, 4'b0001, 32'h29);
    digits();
    rd_chk(2'd3, 32'h00006F91, "R6 reflected 16-bit checksum");

    // R7 32-bit mode
    wr(2'd0, 4'b0001, 32'h03);
    digits();
    rd_chk(2'd3, 32'h0376E6E7, "R7 32-bit checksum");
    wr(2'd0, 4'b0001, 32'h42);
    rd_chk(2'd3, 32'hFC891918, "R7 32-bit with inversion");
    wr(2'd0, 4'b0001, 32'h6B);
    digits();
    rd_chk(2'd3, 32'hCBF43926, "R7 reflected inverted 32-bit");

    // R10 seed handling
    wr(2'd1, 4'b1111, 32'h00000000);
    rd_chk(2'd1, 32'h00000000, "R10 seed written");
    rd_chk(2'd3, 32'hCBF43926, "R10 state unchanged by seed write");
    wr(2'd0, 4'b0001, 32'h01);
    rd_chk(2'd3, 32'h00000000, "R10 init loads new seed");
    digits();
    rd_chk(2'd3, 32'h000031C3, "R10 checksum from zero seed");
    wr(2'd1, 4'b0001, 32'hAAAA55FF);
    rd_chk(2'd1, 32'h000000FF, "R10 seed partial write");

    // R11 writes without effect
    wr(2'd2, 4'b0000, 32'hFFFFFFFF);
    rd_chk(2'd3, 32'h000031C3, "R11 empty data write ignored");
    wr(2'd3, 4'b1111, 32'h12345678);
    rd_chk(2'd3, 32'h000031C3, "R11 result write ignored");
    wr(2'd0, 4'b0010, 32'h0000007F);
    rd_chk(2'd0, 32'h00000000, "R11 control lane 0 disabled ignored");
    rd_chk(2'd3, 32'h000031C3, "R11 state unchanged by masked control");

    // R1 reset in mid-run
    wr(2'd0, 4'b0001, 32'h6B);
    do_reset();
    rd_chk(2'd0, 32'h00000000, "R1 control after second reset");
    rd_chk(2'd1, 32'hFFFFFFFF, "R1 seed after second reset");
    rd_chk(2'd3, 32'h0000FFFF, "R1 result after second reset");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule